// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter Pair

This block holds two timer/counters. Each one is built from a low count byte and a high count byte. A mode field selects how each pair of bytes counts: as a 13-bit prescaled counter, as a 16-bit counter, or as an 8-bit counter whose low byte reloads from the high byte. In a fourth, split arrangement Timer 0 becomes two independent 8-bit counters. The high half of Timer 0 then takes over Timer 1's run bit and Timer 1's overflow flag. Timer 1 in that same arrangement stops counting.

Each timer counts either machine cycles or falling edges on its own external count pin. The machine-cycle pulse `cycEn` is one clock wide and arrives once every twelve core clocks. Each timer can also be gated by its own external gate pin, which allows pulse-width measurement. Software loads the configuration and the count bytes through a small register port, and reads them back through the same port. Each overflow sets a sticky flag. The flag is cleared by software or by an acknowledge input.

Top module: `dual_timer_pair`

Register port map (`regAddr`): 0 = Timer 0 low byte, 1 = Timer 0 high byte, 2 = Timer 1 low byte, 3 = Timer 1 high byte, 4 = mode register, 5 = control register. Addresses 6 and 7 read as zero.
- Mode register fields: [1:0] Timer 0 mode, [2] Timer 0 source, [3] Timer 0 gate enable, [5:4] Timer 1 mode, [6] Timer 1 source, [7] Timer 1 gate enable.
- Mode codes: 0 = 13-bit, 1 = 16-bit, 2 = 8-bit auto-reload, 3 = split.
- Control register fields: [0] Timer 0 run, [1] Timer 1 run, [2] Timer 0 overflow flag, [3] Timer 1 overflow flag.

## Requirements
- R1: After reset, all four count bytes, the mode register (address 4) and the control register (address 5) read 0, and `ovfFlag` and `t1Ovf` are low.
- R2: In mode code 1, the timer's high:low bytes form a 16-bit count. The count goes up by one per enabled count event. Wrapping from 0xFFFF to 0x0000 sets the timer's overflow flag.
- R3: In mode code 0, the count is 13 bits, formed as {high byte, low byte bits [4:0]}. Low byte bits [7:5] never change through counting. Wrapping from 0x1FFF sets the overflow flag.
- R4: In mode code 2, only the low byte counts. When it is 0xFF, the next event loads it from the high byte and sets the overflow flag. Counting never changes the high byte.
- R5: A timer counts only when its run bit is 1 and either its gate-enable bit (mode bit 3 or 7) is 0 or its `gatePin` is high. `gatePin` passes through a two-flop synchronizer before use.
- R6: With the source bit set (mode bit 2 or 6), the timer counts one event per falling edge of its `cntPin`. The pin is synchronized by two flops and sampled once per `cycEn`. A low level that lasts several machine cycles counts once.
- R7: Clearing a run bit freezes the count. Setting the run bit again resumes counting from the held value, without clearing it.
- R8: Timer 1 in mode code 3 holds its count even when its run bit is 1.
- R9: With Timer 0 in mode code 3, the low byte of Timer 0 is an 8-bit counter that uses Timer 0's run, gate, source and flag. The high byte of Timer 0 counts every `cycEn` while the Timer 1 run bit is 1, and it sets the Timer 1 flag on wrap from 0xFF.
- R10: While Timer 0 is in mode code 3, Timer 1 still counts in modes 0 to 2 and never sets the Timer 1 flag. `t1Ovf` pulses high for one cycle, in the same cycle the wrapped count first appears.
- R11: Overflow flags stay set until `ackIn` or a write to the control register clears them. An overflow in the same cycle as an acknowledge leaves the flag set.
- R12: A write to a count byte takes priority over an increment of that byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycEn | input | 1 | Machine-cycle pulse, one clock wide |
| cntPin | input | 2 | External count inputs, bit n for Timer n |
| gatePin | input | 2 | External gate inputs, bit n for Timer n |
| ackIn | input | 2 | Overflow acknowledge, bit n clears flag n |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, combinational on `regAddr` |
| ovfFlag | output | 2 | Sticky overflow flags for Timer 0 and Timer 1 |
| t1Ovf | output | 1 | One-cycle pulse on each Timer 1 count wrap |

## Verification
A wrong internal state has different symptoms at the ports:
- **Corrupted count byte:** shows on `regRdata` at the next read.
- **Wrong carry split in the 13-bit mode:** disturbs low byte bits [7:5] or the high byte on the first event that crosses bit 4.
- **Reload fault:** appears one event after the low byte reaches 0xFF.
- **Misrouted split-mode overflow:** sets the wrong bit of `ovfFlag` in the cycle that follows the wrapping event.

The bench sweeps start values and event counts, and it computes each expected count arithmetically. Because of this, a wrong result is seen within a few machine cycles of its cause.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

  localparam int NUM_TMR    = 2;
  localparam int REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] ADDR_MODE = 3'd4;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 3'd5;

  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_TMR-1:0] tick;     // gated count event per timer
    logic               splitTick;   // timer0 high byte event in split mode
    logic               splitActive; // timer0 is in split mode
    tmrMode_e           mode0;
    tmrMode_e           mode1;
  } tmrStrobe_t;

endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import tmr_pair_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cycEn,
  input  logic [NUM_TMR-1:0] cntPin,
  input  logic [NUM_TMR-1:0] gatePin,
  input  logic [7:0]         modeReg,
  input  logic [NUM_TMR-1:0] runBits,
  output tmrStrobe_t         strobe
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [NUM_TMR-1:0] srcSel, gateSel, fallEv, gateOpen, srcEv, runOk;
  tmrMode_e mode0, mode1;

  assign mode0      = tmrMode_e'(modeReg[1:0]);
  assign mode1      = tmrMode_e'(modeReg[5:4]);
  assign srcSel     = {modeReg[6], modeReg[2]};
  assign gateSel    = {modeReg[7], modeReg[3]};

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_src
    logic [SYNC_STAGES-1:0] cntSh, gateSh;
    logic                   cntPrev;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntSh   <= '0;
        gateSh  <= '0;
        cntPrev <= 1'b0;
      end else begin
        cntSh  <= {cntSh[SYNC_STAGES-2:0], cntPin[t]};
        gateSh <= {gateSh[SYNC_STAGES-2:0], gatePin[t]};
        if (cycEn) cntPrev <= cntSh[TOP];
      end
    end

    assign fallEv[t]   = cycEn & cntPrev & ~cntSh[TOP];
    assign gateOpen[t] = ~gateSel[t] | gateSh[TOP];
    assign srcEv[t]    = srcSel[t] ? fallEv[t] : cycEn;
    assign runOk[t]    = runBits[t] & gateOpen[t];
  end

  always_comb begin
    strobe.mode0       = mode0;
    strobe.mode1       = mode1;
    strobe.tick[0]     = runOk[0] & srcEv[0];
    strobe.tick[1]     = runOk[1] & srcEv[1] & (mode1 != MODE_SPLIT);
    strobe.splitActive = (mode0 == MODE_SPLIT);
    strobe.splitTick   = (mode0 == MODE_SPLIT) & cycEn & runBits[1];
  end

endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import tmr_pair_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int M0_LOW_BITS = 5
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  tmrStrobe_t                      strobe,
  input  logic                            regWr,
  input  logic [REG_ADDR_W-1:0]           regAddr,
  input  logic [BYTE_W-1:0]               regWdata,
  input  logic [NUM_TMR-1:0]              ackIn,
  output logic [NUM_TMR-1:0][BYTE_W-1:0]  cntLo,
  output logic [NUM_TMR-1:0][BYTE_W-1:0]  cntHi,
  output logic [BYTE_W-1:0]               modeReg,
  output logic [NUM_TMR-1:0]              runBits,
  output logic [NUM_TMR-1:0]              ovfFlag,
  output logic                            t1Ovf,
  output logic [BYTE_W-1:0]               regRdata
);

  localparam int M0_W   = BYTE_W + M0_LOW_BITS;
  localparam int FULL_W = 2 * BYTE_W;

  logic [NUM_TMR-1:0] ovfEv, flagSet;
  logic               splitHiOvf, ctrlWr;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_cnt
    logic [BYTE_W-1:0] lo, hi, incLo, incHi, nextLo, nextHi;
    logic [M0_W-1:0]   m0Sum;
    logic [FULL_W-1:0] m1Sum;
    logic              allOnes, tick, hiSplitTick, wrLo, wrHi;
    tmrMode_e          md;

    assign md          = (t == 0) ? strobe.mode0 : strobe.mode1;
    assign tick        = strobe.tick[t];
    assign hiSplitTick = (t == 0) ? strobe.splitTick : 1'b0;
    assign wrLo        = regWr && (regAddr == REG_ADDR_W'(2 * t));
    assign wrHi        = regWr && (regAddr == REG_ADDR_W'(2 * t + 1));
    assign m0Sum       = {hi, lo[M0_LOW_BITS-1:0]} + M0_W'(1);
    assign m1Sum       = {hi, lo} + FULL_W'(1);

    always_comb begin
      incLo   = lo;
      incHi   = hi;
      allOnes = 1'b0;
      unique case (md)
        MODE_13: begin
          allOnes = &{hi, lo[M0_LOW_BITS-1:0]};
          incLo   = {lo[BYTE_W-1:M0_LOW_BITS], m0Sum[M0_LOW_BITS-1:0]};
          incHi   = m0Sum[M0_W-1:M0_LOW_BITS];
        end
        MODE_16: begin
          allOnes        = &{hi, lo};
          {incHi, incLo} = m1Sum;
        end
        MODE_RELOAD: begin
          allOnes = &lo;
          incLo   = allOnes ? hi : lo + BYTE_W'(1);
        end
        default: begin
          allOnes = &lo;
          incLo   = lo + BYTE_W'(1);
        end
      endcase
    end

    always_comb begin
      if (wrLo)      nextLo = regWdata;
      else if (tick) nextLo = incLo;
      else           nextLo = lo;

      if (wrHi)             nextHi = regWdata;
      else if (hiSplitTick) nextHi = hi + BYTE_W'(1);
      else if (tick)        nextHi = incHi;
      else                  nextHi = hi;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lo <= '0;
        hi <= '0;
      end else begin
        lo <= nextLo;
        hi <= nextHi;
      end
    end

    assign ovfEv[t] = tick & allOnes;
    assign cntLo[t] = lo;
    assign cntHi[t] = hi;
  end

  assign splitHiOvf = strobe.splitTick & (&cntHi[0]);
  assign flagSet    = {(strobe.splitActive ? splitHiOvf : ovfEv[1]), ovfEv[0]};
  assign ctrlWr     = regWr && (regAddr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      runBits <= '0;
      ovfFlag <= '0;
      t1Ovf   <= 1'b0;
    end else begin
      if (regWr && (regAddr == ADDR_MODE)) modeReg <= regWdata;
      if (ctrlWr) runBits <= regWdata[1:0];
      ovfFlag <= flagSet | (ctrlWr ? regWdata[3:2] : (ovfFlag & ~ackIn));
      t1Ovf   <= ovfEv[1];
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      3'd0:      regRdata = cntLo[0];
      3'd1:      regRdata = cntHi[0];
      3'd2:      regRdata = cntLo[1];
      3'd3:      regRdata = cntHi[1];
      ADDR_MODE: regRdata = modeReg;
      ADDR_CTRL: regRdata = {{(BYTE_W-4){1'b0}}, ovfFlag, runBits};
      default:   regRdata = '0;
    endcase
  end

endmodule

// File: rtl/dual_timer_pair.sv
module dual_timer_pair
  import tmr_pair_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int M0_LOW_BITS = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cycEn,
  input  logic [NUM_TMR-1:0]    cntPin,
  input  logic [NUM_TMR-1:0]    gatePin,
  input  logic [NUM_TMR-1:0]    ackIn,
  input  logic                  regWr,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0]     regWdata,
  output logic [BYTE_W-1:0]     regRdata,
  output logic [NUM_TMR-1:0]    ovfFlag,
  output logic                  t1Ovf
);

  tmrStrobe_t                     strobe;
  logic [NUM_TMR-1:0][BYTE_W-1:0] cntLo, cntHi;
  logic [BYTE_W-1:0]              modeReg;
  logic [NUM_TMR-1:0]             runBits;

  timer_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cycEn   (cycEn),
    .cntPin  (cntPin),
    .gatePin (gatePin),
    .modeReg (modeReg[7:0]),
    .runBits (runBits),
    .strobe  (strobe)
  );

  timer_datapath #(.BYTE_W(BYTE_W), .M0_LOW_BITS(M0_LOW_BITS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .ackIn    (ackIn),
    .cntLo    (cntLo),
    .cntHi    (cntHi),
    .modeReg  (modeReg),
    .runBits  (runBits),
    .ovfFlag  (ovfFlag),
    .t1Ovf    (t1Ovf),
    .regRdata (regRdata)
  );

endmodule

// File: rtl/timer_pair_checker.sv
module timer_pair_checker (
  input logic            clk,
  input logic            rstN,
  input logic            regWr,
  input logic [2:0]      regAddr,
  input logic [1:0]      ackIn,
  input logic [1:0]      ovfFlag,
  input logic [1:0][7:0] cntLo,
  input logic [1:0][7:0] cntHi,
  input logic [7:0]      modeReg,
  input logic [1:0]      runBits
);

  logic wrLo0, wrHi0, wrT1, wrCtrl;
  assign wrLo0  = regWr && (regAddr == 3'd0);
  assign wrHi0  = regWr && (regAddr == 3'd1);
  assign wrT1   = regWr && ((regAddr == 3'd2) || (regAddr == 3'd3));
  assign wrCtrl = regWr && (regAddr == 3'd5);

  // R11: flag sticky without ack or control write
  a_r11_flag0_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag[0] && !ackIn[0] && !wrCtrl |=> ovfFlag[0]);
  a_r11_flag1_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag[1] && !ackIn[1] && !wrCtrl |=> ovfFlag[1]);

  // R8: timer1 frozen in split code
  a_r8_t1_hold: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[5:4] == 2'd3) && !wrT1 |=> $stable(cntLo[1]) && $stable(cntHi[1]));

  // R4: reload source untouched by counting
  a_r4_reload_hi_kept: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[1:0] == 2'd2) && !wrHi0 |=> $stable(cntHi[0]));

  // R3: upper low-byte bits untouched in 13-bit code
  a_r3_upper_bits: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[1:0] == 2'd0) && !wrLo0 |=> $stable(cntLo[0][7:5]));

  // R7: stopped timer0 holds
  a_r7_stop_hold: assert property (@(posedge clk) disable iff (!rstN)
    !runBits[0] && (modeReg[1:0] != 2'd3) && !wrLo0 && !wrHi0
    |=> $stable(cntLo[0]) && $stable(cntHi[0]));

endmodule

bind dual_timer_pair timer_pair_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regWr   (regWr),
  .regAddr (regAddr),
  .ackIn   (ackIn),
  .ovfFlag (ovfFlag),
  .cntLo   (cntLo),
  .cntHi   (cntHi),
  .modeReg (modeReg),
  .runBits (runBits)
);

// File: tb/dual_timer_pair_tb.sv
module dual_timer_pair_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cycEn = 1'b0;
  logic [1:0] cntPin = 2'b00;
  logic [1:0] gatePin = 2'b00;
  logic [1:0] ackIn = 2'b00;
  logic       regWr = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic [1:0] ovfFlag;
  logic       t1Ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_timer_pair u_dut (
    .clk(clk), .rstN(rstN), .cycEn(cycEn), .cntPin(cntPin), .gatePin(gatePin),
    .ackIn(ackIn), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .ovfFlag(ovfFlag), .t1Ovf(t1Ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdata;
  endtask

  task automatic rd16(input int t, output logic [15:0] v);
    logic [7:0] l, h;
    rd(3'(2 * t), l); rd(3'(2 * t + 1), h);
    v = {h, l};
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cycEn = 1'b1;
      @(negedge clk); cycEn = 1'b0;
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    logic [16:0] sum;
    logic [15:0] starts [3] = '{16'hFFF0, 16'h00FE, 16'h12FF};
    int          lens [2] = '{3, 17};
    logic [7:0]  m0Lo [3] = '{8'hBE, 8'h1F, 8'hE3};
    logic [7:0]  m0Hi [3] = '{8'hFF, 8'h3C, 8'h00};

    settle(3); rstN = 1'b1; settle(1);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), b); chk("R1 reg reset", b, 0);
    end
    chk("R1 flags reset", {ovfFlag, t1Ovf}, 0);

    // R2 16-bit sweep
    wr(3'd4, 8'h01);
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 2; k++) begin
        wr(3'd5, 8'h00);
        wr(3'd0, starts[s][7:0]); wr(3'd1, starts[s][15:8]);
        wr(3'd5, 8'h01);
        tick(lens[k]);
        sum = {1'b0, starts[s]} + 17'(lens[k]);
        chk("R2 flag", ovfFlag[0], sum[16]);
        rd16(0, v); chk("R2 count", v, sum[15:0]);
      end
    end

    // R3 13-bit sweep
    wr(3'd4, 8'h00);
    for (int s = 0; s < 3; s++) begin
      logic [13:0] c13;
      wr(3'd5, 8'h00);
      wr(3'd0, m0Lo[s]); wr(3'd1, m0Hi[s]);
      wr(3'd5, 8'h01);
      tick(5);
      c13 = {1'b0, m0Hi[s], m0Lo[s][4:0]} + 14'd5;
      chk("R3 flag", ovfFlag[0], c13[13]);
      rd16(0, v); chk("R3 count", v, {c13[12:5], m0Lo[s][7:5], c13[4:0]});
    end

    // R4 auto-reload
    wr(3'd4, 8'h02); wr(3'd5, 8'h00);
    wr(3'd0, 8'hFD); wr(3'd1, 8'hFC);
    wr(3'd5, 8'h01);
    begin
      logic [7:0] m = 8'hFD;
      for (int i = 0; i < 10; i++) m = (m == 8'hFF) ? 8'hFC : m + 8'd1;
      tick(10);
      chk("R4 flag", ovfFlag[0], 1);
      rd16(0, v); chk("R4 count", v, {8'hFC, m});
    end

    // R5 gate
    wr(3'd5, 8'h00); wr(3'd4, 8'h09);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd5, 8'h01);
    gatePin[0] = 1'b0; settle(3); tick(4);
    rd16(0, v); chk("R5 gate low blocks", v, 0);
    gatePin[0] = 1'b1; settle(3); tick(4);
    rd16(0, v); chk("R5 gate high counts", v, 4);
    gatePin[0] = 1'b0;

    // R6 external falling edges
    wr(3'd5, 8'h00); wr(3'd4, 8'h05);
    cntPin[0] = 1'b1; settle(3); tick(1);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd5, 8'h01);
    tick(3);
    rd16(0, v); chk("R6 no edge no count", v, 0);
    for (int i = 0; i < 5; i++) begin
      cntPin[0] = 1'b0; settle(3); tick(2);
      cntPin[0] = 1'b1; settle(3); tick(1);
    end
    rd16(0, v); chk("R6 edge count", v, 5);

    // R7 stop and resume
    wr(3'd4, 8'h01); wr(3'd0, 8'h40); wr(3'd1, 8'h00);
    wr(3'd5, 8'h00); tick(5);
    rd16(0, v); chk("R7 held", v, 16'h0040);
    wr(3'd5, 8'h01); tick(2);
    rd16(0, v); chk("R7 resumed", v, 16'h0042);

    // R8 timer1 frozen in split code
    wr(3'd5, 8'h00); wr(3'd4, 8'h31);
    wr(3'd2, 8'h55); wr(3'd3, 8'h66);
    wr(3'd5, 8'h02); tick(5);
    rd16(1, v); chk("R8 t1 held", v, 16'h6655);

    // R9 timer0 split
    wr(3'd5, 8'h00); wr(3'd4, 8'h13);
    wr(3'd0, 8'hFE); wr(3'd1, 8'hFD);
    wr(3'd5, 8'h03); tick(3);
    chk("R9 both flags", ovfFlag, 2'b11);
    rd16(0, v); chk("R9 halves", v, 16'h0001);
    wr(3'd5, 8'h02); tick(2);
    rd16(0, v); chk("R9 high on run1 only", v, 16'h0201);

    // R10 timer1 runs without flag, pulses t1Ovf
    wr(3'd5, 8'h00);
    wr(3'd1, 8'h00); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    wr(3'd5, 8'h02); tick(1);
    chk("R10 no pulse yet", t1Ovf, 0);
    tick(1);
    chk("R10 pulse", t1Ovf, 1);
    chk("R10 no flag1", ovfFlag[1], 0);
    rd16(1, v); chk("R10 t1 wrapped", v, 0);
    chk("R10 pulse one cycle", t1Ovf, 0);

    // R11 flag stickiness and clearing
    wr(3'd5, 8'h00); wr(3'd4, 8'h01);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd5, 8'h01);
    tick(1); tick(2);
    chk("R11 sticky", ovfFlag[0], 1);
    @(negedge clk); ackIn[0] = 1'b1; @(negedge clk); ackIn[0] = 1'b0;
    chk("R11 ack clears", ovfFlag[0], 0);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); tick(1);
    wr(3'd5, 8'h01);
    chk("R11 write clears", ovfFlag[0], 0);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    @(negedge clk); cycEn = 1'b1; ackIn[0] = 1'b1;
    @(negedge clk); cycEn = 1'b0; ackIn[0] = 1'b0;
    chk("R11 set beats ack", ovfFlag[0], 1);

    // R12 write priority
    wr(3'd0, 8'h10);
    @(negedge clk); cycEn = 1'b1; regWr = 1'b1; regAddr = 3'd0; regWdata = 8'h80;
    @(negedge clk); cycEn = 1'b0; regWr = 1'b0;
    rd(3'd0, b); chk("R12 write wins", b, 8'h80);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule